// File: doc/BRIEF.md
# SPI Target with Register Interface

This block is the target (slave) end of a four-wire SPI link with a small register file on the system side. An external controller owns the serial clock and the active-low select line; the block brings both lines and the controller's data line into the system clock domain. It shifts one word out on `misoOut` while it captures one word from `mosiIn`, so every transfer is full duplex. Word width, bit order, clock polarity and clock phase are fixed by parameters and must agree with the controller.

Software loads outgoing words into a transmit holding register and collects incoming words from a receive register. Each side has one word of buffering between its holding register and the shift register. Status flags report a free transmit holding register, an empty shift register, a waiting received word, overruns on either side and a combined error. A control register picks which flags raise the interrupt line. The block cannot start a transfer. It keeps `misoOut` driven at all times, including when it is not selected.

Top module: `spi_target_mmio`

## Requirements
- R1: After reset, status (offset 2) reads 0x0060 (bit 6 transmit-ready and bit 5 shift-empty set), control (offset 3) reads 0, receive (offset 0) reads 0, and `irqOut` is 0.
- R2: While `selNIn` is low, each word of DATA_W bits is captured from `mosiIn` on the sampling edge, and the shift register's bits appear on `misoOut`. The default is MSB first, with CPOL=0 and CPHA=0. The alternate build uses LSB first with CPOL=1 and CPHA=1. Only sclk edges seen after two-stage synchronization count, so the system clock must run at least four times faster than sclk.
- R3: With CPHA=0, the first bit of the loaded word is already on `misoOut` before the first sclk edge. With CPHA=1, the first bit is held through the first leading edge.
- R4: A completed word is written to the receive register and sets receive-ready (status bit 7). A read of offset 0 clears receive-ready. A write to offset 0 has no effect.
- R5: If a word completes while receive-ready is already set, the receive overrun bit (status bit 3) and the error bit (status bit 8) are set, and the new word replaces the old one.
- R6: A write to offset 1 while transmit-ready (bit 6) is 1 is accepted and clears transmit-ready. The word moves to the shift register when the shift register is empty and no word is in progress, or at the end of the current word, and transmit-ready returns to 1. Shift-empty (bit 5) is 0 while the shift register holds a word.
- R7: A write to offset 1 while transmit-ready is 0 sets the transmit overrun bit (bit 4) and the error bit (bit 8), and its data is discarded.
- R8: Any write to offset 2 clears bits 3, 4 and 8. Reading status changes nothing.
- R9: When a word completes and no word is waiting, the shift register empties: shift-empty reads 1 and the next transfer sends all zeros.
- R10: Raising `selNIn` in the middle of a word discards the partial received word and leaves receive-ready and the receive register unchanged. The partly sent word is dropped and the bit counter restarts.
- R11: While not selected, sclk edges are ignored, and `misoOut` still carries a defined value (the first bit of the shift register).
- R12: Control bits 3, 4, 6, 7 and 8 enable the status bits at the same positions. `irqOut` is the OR of enabled set status bits. Control reads back only those bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Serial clock from the controller (asynchronous) |
| mosiIn | input | 1 | Serial data from the controller (asynchronous) |
| selNIn | input | 1 | Active-low select from the controller (asynchronous) |
| misoOut | output | 1 | Serial data to the controller |
| regAddr | input | 3 | Register offset: 0 receive, 1 transmit, 2 status, 3 control |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects only on offset 0) |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, valid in the same cycle as the address |
| irqOut | output | 1 | Interrupt request |

## Verification
A shift register out of step with the bit counter shows up as a wrong word on `misoOut`, seen within one transfer. A lost or doubled sclk edge, for example from a badly handled deselect, gives a word that lands shifted by one bit, or a receive-ready that never rises. A flag that does not set or clear is visible on the next status read and on `irqOut` one cycle after the event that changed it. Each of these paths is exercised by a directed case and by a seeded random run.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_RX   = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_TX   = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd3;

  // status bit positions; control enables share them
  localparam int unsigned ST_RXOVR   = 3;
  localparam int unsigned ST_TXOVR   = 4;
  localparam int unsigned ST_TXEMPTY = 5;
  localparam int unsigned ST_TXRDY   = 6;
  localparam int unsigned ST_RXRDY   = 7;
  localparam int unsigned ST_ERR     = 8;

  localparam logic [REG_W-1:0] IEN_MASK =
    (REG_W'(1) << ST_RXOVR) | (REG_W'(1) << ST_TXOVR) | (REG_W'(1) << ST_TXRDY) |
    (REG_W'(1) << ST_RXRDY) | (REG_W'(1) << ST_ERR);

  // control -> datapath
  typedef struct packed {
    logic holdWrite;   // accepted write into the transmit holding register
    logic holdValid;   // holding register carries a word
  } tgtStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic wordDone;      // a full word was received this cycle
    logic holdConsumed;  // holding word moved into the shift register
    logic shiftFull;     // shift register carries a word
  } tgtEvent_t;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic mosiIn,
  input  logic selNIn,
  output logic sampleEdge,
  output logic shiftEdge,
  output logic mosiBit,
  output logic selActive,
  output logic selDrop
);
  localparam int CHAIN_W = 3 * STAGES;
  localparam logic [2:0] IDLE_VAL = {CPOL, 1'b1, 1'b0};  // {sclk, sel, mosi}

  logic [CHAIN_W-1:0] chain;
  logic [2:0] synced;
  logic sclkPrev, selPrev;
  logic clkMoved, leadEdge, trailEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain    <= {STAGES{IDLE_VAL}};
      sclkPrev <= CPOL;
      selPrev  <= 1'b1;
    end else begin
      chain    <= {chain[CHAIN_W-4:0], sclkIn, selNIn, mosiIn};
      sclkPrev <= synced[2];
      selPrev  <= synced[1];
    end
  end

  assign synced    = chain[CHAIN_W-1 -: 3];
  assign mosiBit   = synced[0];
  assign selActive = ~synced[1];
  assign selDrop   = synced[1] & ~selPrev;

  assign clkMoved  = synced[2] ^ sclkPrev;
  assign leadEdge  = clkMoved & (synced[2] != CPOL);
  assign trailEdge = clkMoved & (synced[2] == CPOL);

  generate
    if (CPHA == 1'b0) begin : g_phase0
      assign sampleEdge = leadEdge & selActive;
      assign shiftEdge  = trailEdge & selActive;
    end else begin : g_phase1
      assign sampleEdge = trailEdge & selActive;
      assign shiftEdge  = leadEdge & selActive;
    end
  endgenerate
endmodule

// File: rtl/spi_tgt_dpath.sv
module spi_tgt_dpath
  import spi_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit LSB_FIRST = 1'b0,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tgtStrobe_t        stb,
  input  logic [DATA_W-1:0] wrWord,
  input  logic              sampleEdge,
  input  logic              shiftEdge,
  input  logic              mosiBit,
  input  logic              selDrop,
  output tgtEvent_t         evt,
  output logic [DATA_W-1:0] rxWord,
  output logic [CNT_W-1:0]  bitCount,
  output logic              misoOut
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] txHold, shiftReg, shiftNext, rxShift, rxNext, rxHold;
  logic [CNT_W-1:0]  bitCnt;
  logic shiftFull, wordEnd, loadIdle, abortNow;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign rxNext    = {mosiBit, rxShift[DATA_W-1:1]};
      assign shiftNext = {1'b0, shiftReg[DATA_W-1:1]};
      assign misoOut   = shiftReg[0];
    end else begin : g_msb
      assign rxNext    = {rxShift[DATA_W-2:0], mosiBit};
      assign shiftNext = {shiftReg[DATA_W-2:0], 1'b0};
      assign misoOut   = shiftReg[DATA_W-1];
    end
  endgenerate

  assign wordEnd  = sampleEdge && (bitCnt == LAST);
  assign abortNow = selDrop && (bitCnt != '0);
  assign loadIdle = stb.holdValid && !shiftFull && (bitCnt == '0) && !abortNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold <= '0;
    end else if (stb.holdWrite) begin
      txHold <= wrWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      shiftFull <= 1'b0;
      rxShift   <= '0;
      rxHold    <= '0;
      bitCnt    <= '0;
    end else if (abortNow) begin
      shiftReg  <= '0;
      shiftFull <= 1'b0;
      bitCnt    <= '0;
    end else if (wordEnd) begin
      rxHold <= rxNext;
      rxShift <= rxNext;
      bitCnt <= '0;
      if (stb.holdValid) begin
        shiftReg  <= txHold;
        shiftFull <= 1'b1;
      end else begin
        shiftReg  <= '0;
        shiftFull <= 1'b0;
      end
    end else begin
      if (sampleEdge) begin
        rxShift <= rxNext;
        bitCnt  <= bitCnt + 1'b1;
      end
      if (shiftEdge && (bitCnt != '0)) begin
        shiftReg <= shiftNext;
      end
      if (loadIdle) begin
        shiftReg  <= txHold;
        shiftFull <= 1'b1;
      end
    end
  end

  assign evt.wordDone     = wordEnd;
  assign evt.holdConsumed = loadIdle || (wordEnd && stb.holdValid);
  assign evt.shiftFull    = shiftFull;
  assign rxWord           = rxHold;
  assign bitCount         = bitCnt;
endmodule

// File: rtl/spi_tgt_ctrl.sv
module spi_tgt_ctrl
  import spi_tgt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [REG_W-1:0]  regWdata,
  input  tgtEvent_t         evt,
  input  logic [DATA_W-1:0] rxWord,
  output tgtStrobe_t        stb,
  output logic [REG_W-1:0]  regRdata,
  output logic [REG_W-1:0]  statusVec,
  output logic              irqOut
);
  logic txFull, rxReady, roeFlag, toeFlag, errFlag;
  logic [REG_W-1:0] ctrlReg;
  logic hitTx, hitRx, hitStat, hitCtrl;
  logic rxTake, roeSet, toeSet, flagClear;

  assign hitRx   = (regAddr == OFF_RX);
  assign hitTx   = (regAddr == OFF_TX);
  assign hitStat = (regAddr == OFF_STAT);
  assign hitCtrl = (regAddr == OFF_CTRL);

  assign rxTake    = regRd && hitRx;
  assign flagClear = regWr && hitStat;
  assign toeSet    = regWr && hitTx && txFull;
  assign roeSet    = evt.wordDone && rxReady && !rxTake;

  assign stb.holdWrite = regWr && hitTx && !txFull;
  assign stb.holdValid = txFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txFull  <= 1'b0;
      rxReady <= 1'b0;
      roeFlag <= 1'b0;
      toeFlag <= 1'b0;
      errFlag <= 1'b0;
      ctrlReg <= '0;
    end else begin
      if (stb.holdWrite)         txFull <= 1'b1;
      else if (evt.holdConsumed) txFull <= 1'b0;

      if (evt.wordDone)  rxReady <= 1'b1;
      else if (rxTake)   rxReady <= 1'b0;

      if (roeSet)         roeFlag <= 1'b1;
      else if (flagClear) roeFlag <= 1'b0;

      if (toeSet)         toeFlag <= 1'b1;
      else if (flagClear) toeFlag <= 1'b0;

      if (roeSet || toeSet) errFlag <= 1'b1;
      else if (flagClear)   errFlag <= 1'b0;

      if (regWr && hitCtrl) ctrlReg <= regWdata & IEN_MASK;
    end
  end

  always_comb begin
    statusVec = '0;
    statusVec[ST_RXOVR]   = roeFlag;
    statusVec[ST_TXOVR]   = toeFlag;
    statusVec[ST_TXEMPTY] = !evt.shiftFull;
    statusVec[ST_TXRDY]   = !txFull;
    statusVec[ST_RXRDY]   = rxReady;
    statusVec[ST_ERR]     = errFlag;
  end

  always_comb begin
    regRdata = '0;
    if (hitRx)        regRdata[DATA_W-1:0] = rxWord;
    else if (hitStat) regRdata = statusVec;
    else if (hitCtrl) regRdata = ctrlReg;
  end

  assign irqOut = |(statusVec & ctrlReg);
endmodule

// File: rtl/spi_target_mmio.sv
module spi_target_mmio
  import spi_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit LSB_FIRST = 1'b0,
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkIn,
  input  logic        mosiIn,
  input  logic        selNIn,
  output logic        misoOut,
  input  logic [2:0]  regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  output logic        irqOut
);
  localparam int CNT_W = $clog2(DATA_W);

  logic sampleEdge, shiftEdge, mosiBit, selActive, selDrop;
  tgtStrobe_t stb;
  tgtEvent_t evt;
  logic [DATA_W-1:0] rxWord;
  logic [CNT_W-1:0] bitCount;
  logic [REG_W-1:0] statusVec;

  spi_tgt_sync #(.CPOL(CPOL), .CPHA(CPHA), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .mosiIn(mosiIn), .selNIn(selNIn),
    .sampleEdge(sampleEdge), .shiftEdge(shiftEdge), .mosiBit(mosiBit),
    .selActive(selActive), .selDrop(selDrop)
  );

  spi_tgt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .evt(evt), .rxWord(rxWord), .stb(stb),
    .regRdata(regRdata), .statusVec(statusVec), .irqOut(irqOut)
  );

  spi_tgt_dpath #(.DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrWord(regWdata[DATA_W-1:0]),
    .sampleEdge(sampleEdge), .shiftEdge(shiftEdge), .mosiBit(mosiBit),
    .selDrop(selDrop), .evt(evt), .rxWord(rxWord), .bitCount(bitCount),
    .misoOut(misoOut)
  );

  logic unusedSel;
  assign unusedSel = selActive;
endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk
  import spi_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        regAddr,
  input logic              regWr,
  input logic              regRd,
  input logic              holdWrite,
  input logic              wordDone,
  input logic              selDrop,
  input logic [15:0]       statusVec,
  input logic [DATA_W-1:0] rxWord,
  input logic [CNT_W-1:0]  bitCount
);
  p_rxready_r4: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |=> statusVec[ST_RXRDY]);

  p_overrun_r5: assert property (@(posedge clk) disable iff (!rstN)
    wordDone && statusVec[ST_RXRDY] && !(regRd && regAddr == OFF_RX)
      |=> statusVec[ST_RXOVR] && statusVec[ST_ERR]);

  p_err_sum_r5: assert property (@(posedge clk) disable iff (!rstN)
    statusVec[ST_ERR] == (statusVec[ST_RXOVR] | statusVec[ST_TXOVR]));

  p_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    holdWrite |=> !statusVec[ST_TXRDY]);

  p_txovr_r7: assert property (@(posedge clk) disable iff (!rstN)
    regWr && regAddr == OFF_TX && !statusVec[ST_TXRDY]
      |=> statusVec[ST_TXOVR] && statusVec[ST_ERR]);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    regWr && regAddr == OFF_STAT && !wordDone
      |=> !statusVec[ST_RXOVR] && !statusVec[ST_TXOVR] && !statusVec[ST_ERR]);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    selDrop && bitCount != '0 |=> bitCount == '0 && $stable(rxWord));
endmodule

bind spi_target_mmio spi_tgt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
  .holdWrite(stb.holdWrite), .wordDone(evt.wordDone), .selDrop(selDrop),
  .statusVec(statusVec), .rxWord(rxWord), .bitCount(bitCount)
);

// File: tb/tb_spi_target_mmio.sv
`timescale 1ns/1ps
module tb_spi_target_mmio;
  localparam int W = 8;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] sclk = 2'b10, selN = 2'b11, regWr = 2'b00, regRd = 2'b00;
  logic mosi = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [15:0] regWdata = 16'h0;
  logic [15:0] rdata [2];
  logic [1:0] miso, irq;

  spi_target_mmio dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclk[0]), .mosiIn(mosi), .selNIn(selN[0]),
    .misoOut(miso[0]), .regAddr(regAddr), .regWr(regWr[0]), .regRd(regRd[0]),
    .regWdata(regWdata), .regRdata(rdata[0]), .irqOut(irq[0]));

  spi_target_mmio #(.LSB_FIRST(1'b1), .CPOL(1'b1), .CPHA(1'b1)) dutAlt (
    .clk(clk), .rstN(rstN), .sclkIn(sclk[1]), .mosiIn(mosi), .selNIn(selN[1]),
    .misoOut(miso[1]), .regAddr(regAddr), .regWr(regWr[1]), .regRd(regRd[1]),
    .regWdata(regWdata), .regRdata(rdata[1]), .irqOut(irq[1]));

  int checks = 0, fails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic regWrite(input int inst, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr[inst] = 1'b1;
    @(negedge clk);
    regWr[inst] = 1'b0;
  endtask

  task automatic regRead(input int inst, input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRd[inst] = 1'b1;
    #1 d = rdata[inst];
    @(negedge clk);
    regRd[inst] = 1'b0;
  endtask

  // bench-side controller; inst 1 runs CPOL=1, CPHA=1, LSB first
  task automatic xfer(input int inst, input logic [W-1:0] tx, input int nBits,
                      output logic [W-1:0] rx);
    logic pol, pha, lsb;
    pol = (inst == 1); pha = (inst == 1); lsb = (inst == 1);
    rx = '0;
    @(negedge clk);
    selN[inst] = 1'b0;
    if (!pha) mosi = tx[lsb ? 0 : W-1];
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < nBits; k++) begin
      int idx;
      idx = lsb ? k : W-1-k;
      if (!pha) begin
        rx[idx] = miso[inst];
        sclk[inst] = ~pol;
        repeat (HALF) @(negedge clk);
        sclk[inst] = pol;
        if (k + 1 < W) mosi = tx[lsb ? k+1 : W-2-k];
        repeat (HALF) @(negedge clk);
      end else begin
        sclk[inst] = ~pol;
        mosi = tx[idx];
        repeat (HALF) @(negedge clk);
        rx[idx] = miso[inst];
        sclk[inst] = pol;
        repeat (HALF) @(negedge clk);
      end
    end
    selN[inst] = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [W-1:0] got;
    logic expRrdy, expRoe;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    regRead(0, 3'd2, d); check("R1 status", d, 16'h0060);
    regRead(0, 3'd3, d); check("R1 control", d, 16'h0000);
    regRead(0, 3'd0, d); check("R1 rx", d, 16'h0000);
    check("R1 irq", irq[0], 1'b0);
    check("R11 miso defined", $isunknown(miso[0]), 1'b0);

    // R6 load path, R7 overrun on full holding register, R8 clear
    regWrite(0, 3'd1, 16'h00A5);
    repeat (3) @(negedge clk);
    regRead(0, 3'd2, d); check("R6 loaded to shift", d, 16'h0040);
    check("R11 idle miso shows first bit", miso[0], 1'b1);
    regWrite(0, 3'd1, 16'h003C);
    regRead(0, 3'd2, d); check("R6 holding full", d, 16'h0000);
    regWrite(0, 3'd1, 16'h00FF);
    regRead(0, 3'd2, d); check("R7 toe and err", d, 16'h0110);
    regWrite(0, 3'd2, 16'h0000);
    regRead(0, 3'd2, d); check("R8 flags cleared", d, 16'h0000);

    // R2 R3 full duplex, first bit before first edge
    xfer(0, 8'h5A, W, got);
    check("R2 R3 miso word", got, 8'hA5);
    regRead(0, 3'd2, d); check("R4 R6 status after word", d, 16'h00C0);
    regRead(0, 3'd2, d); check("R8 status read no side effect", d, 16'h00C0);
    regRead(0, 3'd0, d); check("R2 rx word", d, 16'h005A);
    regRead(0, 3'd2, d); check("R4 read clears rrdy", d, 16'h0040);
    regWrite(0, 3'd0, 16'h0077);
    regRead(0, 3'd0, d); check("R4 rx write ignored", d, 16'h005A);

    // R9 empty shift register after queue drains; R5 overrun
    xfer(0, 8'hC3, W, got);
    check("R7 ignored word not sent", got, 8'h3C);
    regRead(0, 3'd2, d); check("R9 shift empty", d, 16'h00E0);
    xfer(0, 8'h81, W, got);
    check("R9 zeros when empty", got, 8'h00);
    regRead(0, 3'd2, d); check("R5 overrun flags", d, 16'h01E8);
    regRead(0, 3'd0, d); check("R5 new data overwrites", d, 16'h0081);
    regWrite(0, 3'd2, 16'h0000);
    regRead(0, 3'd2, d); check("R8 clear after overrun", d, 16'h0060);

    // R12 interrupts
    regWrite(0, 3'd3, 16'hFFFF);
    regRead(0, 3'd3, d); check("R12 control readback", d, 16'h01D8);
    check("R12 irq on trdy", irq[0], 1'b1);
    regWrite(0, 3'd3, 16'h0080);
    check("R12 irq masked", irq[0], 1'b0);
    xfer(0, 8'h11, W, got);
    check("R12 irq on rrdy", irq[0], 1'b1);
    regRead(0, 3'd0, d);
    check("R12 irq after rx read", irq[0], 1'b0);
    regWrite(0, 3'd3, 16'h0100);
    regWrite(0, 3'd1, 16'h0012);
    repeat (3) @(negedge clk);
    regWrite(0, 3'd1, 16'h0034);
    regWrite(0, 3'd1, 16'h0056);
    check("R12 irq on err", irq[0], 1'b1);
    regWrite(0, 3'd2, 16'h0000);
    check("R12 irq after clear", irq[0], 1'b0);
    regWrite(0, 3'd3, 16'h0000);
    xfer(0, 8'h00, W, got); check("R6 first queued word", got, 8'h12);
    regRead(0, 3'd0, d);
    xfer(0, 8'h00, W, got); check("R6 second queued word", got, 8'h34);
    regRead(0, 3'd0, d);

    // R10 abort mid-word
    regWrite(0, 3'd1, 16'h0096);
    repeat (3) @(negedge clk);
    regWrite(0, 3'd1, 16'h0069);
    xfer(0, 8'hF0, 3, got);
    regRead(0, 3'd2, d); check("R10 no rrdy after abort", d, 16'h0040);
    regRead(0, 3'd0, d); check("R10 rx unchanged", d, 16'h0000);
    xfer(0, 8'h0F, W, got); check("R10 partial tx dropped", got, 8'h69);
    regRead(0, 3'd0, d); check("R10 counter restarted", d, 16'h000F);

    // R11 sclk ignored while not selected
    for (int k = 0; k < 5; k++) begin
      mosi = k[0];
      sclk[0] = 1'b1; repeat (HALF) @(negedge clk);
      sclk[0] = 1'b0; repeat (HALF) @(negedge clk);
    end
    regRead(0, 3'd2, d); check("R11 no word while deselected", d, 16'h0060);
    xfer(0, 8'hB7, W, got);
    regRead(0, 3'd0, d); check("R11 no stray bits", d, 16'h00B7);

    // R2 R3 alternate build: CPOL=1, CPHA=1, LSB first
    regWrite(1, 3'd1, 16'h0035);
    repeat (3) @(negedge clk);
    xfer(1, 8'hCA, W, got); check("R2 R3 alt miso", got, 8'h35);
    regRead(1, 3'd0, d); check("R2 alt rx", d, 16'h00CA);
    regWrite(1, 3'd1, 16'h0001);
    repeat (3) @(negedge clk);
    xfer(1, 8'h80, W, got); check("R2 alt miso lsb", got, 8'h01);
    regRead(1, 3'd0, d); check("R2 alt rx msb", d, 16'h0080);

    // R2 R4 R5 seeded random words
    expRrdy = 1'b0; expRoe = 1'b0;
    for (int i = 0; i < 30; i++) begin
      logic [W-1:0] t, m;
      t = W'($urandom); m = W'($urandom);
      regWrite(0, 3'd1, {8'h00, t});
      repeat (3) @(negedge clk);
      xfer(0, m, W, got);
      check("R2 random miso", got, t);
      expRoe = expRoe | expRrdy;
      expRrdy = 1'b1;
      regRead(0, 3'd2, d);
      check("R5 random status", d, 16'h0060 | (16'(expRrdy) << 7) | (16'(expRoe) << 3) | (16'(expRoe) << 8));
      if (($urandom % 3) != 0) begin
        regRead(0, 3'd0, d); check("R4 random rx", d, {8'h00, m});
        expRrdy = 1'b0;
      end
      if (expRoe) begin
        regWrite(0, 3'd2, 16'h0000);
        expRoe = 1'b0;
      end
    end

    summary();
    $finish;
  end
endmodule